// File: doc/BRIEF.md
# SPI Slave Word Shifter

This block is a 4-wire SPI slave that moves fixed-length serial words between an external master and two parallel queues. A transmit queue takes words from the core and shifts them out on MISO. A receive queue collects the words captured from MOSI. The word length can be set anywhere from 1 to 16 bits. While chip-select stays asserted, words follow each other with no idle clock between them. A converter frame can therefore be built from several consecutive words; for example, two 11-bit words fill one 22-clock frame.

The SPI pins are sampled in the core clock domain through synchronizer chains, and SCLK edges are detected there. The serial clock must therefore run several times slower than the core clock. The clock idles low. The first rising edge after chip-select falls presents the MSB of the first word. MOSI is captured on every falling edge, and MISO moves on every rising edge.

Both parallel sides are valid/ready streams. On the transmit side, `tx_ready` drops when the queue holds 16 words, and the core must then hold its word until `tx_ready` returns. On the receive side, `rx_valid` holds a word until the core takes it with `rx_ready`. The serial master cannot be stalled. For this reason a full receive queue drops new words and an empty transmit queue sends zeros, and each of these events sets a sticky flag that only reset clears.

Top module: `spi_word_shifter`

## Requirements
- R1: The word length is `cfg_len_m1 + 1` bits, from 1 to 16. Bits go out and come in MSB first. A transmit word uses only the low `cfg_len_m1 + 1` bits of `tx_data`. `cfg_len_m1` changes only while `spi_cs_n` is high.
- R2: MOSI is captured on each falling SCLK edge. When the last bit of a word has been captured, the word is written to the receive queue right-aligned, with its upper bits zero.
- R3: MISO changes only after a rising SCLK edge. On the first rising edge of a word, MISO shows that word's MSB. Each later rising edge of the word moves MISO to the next lower bit.
- R4: While `spi_cs_n` stays low, the rising edge that follows the last bit of a word presents the MSB of the next queued word, with no gap between the words.
- R5: The transmit queue holds up to 16 words in order. `tx_ready` is low exactly while it is full. A word is accepted only on a cycle where `tx_valid` and `tx_ready` are both high.
- R6: `rx_valid` is high while the receive queue is not empty. While `rx_valid` is high and `rx_ready` is low, `rx_data` is held. Words come out in the order they were received.
- R7: If the transmit queue is empty when a word starts, the block shifts out zeros for that word and sets `tx_underrun`, which stays set until reset.
- R8: If a word completes while the receive queue holds 16 words, that word is dropped and `rx_overrun` is set and stays set until reset. The stored words are not changed.
- R9: Raising `spi_cs_n` discards any partial received word, restarts the bit count, and drives MISO to 0. The transmit word that was started for the aborted word is consumed.
- R10: After reset, `tx_ready` is 1, and `rx_valid`, `spi_miso`, `tx_underrun` and `rx_overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len_m1 | input | 4 | Word length minus one |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit queue has room |
| tx_data | input | 16 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Core takes the received word |
| rx_data | output | 16 | Received word, right-aligned |
| tx_underrun | output | 1 | Sticky flag: a word started with an empty transmit queue |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped because the queue was full |

## Verification
The bench sends two 11-bit words in one 22-clock burst and compares MISO on every bit. A design that leaves a gap at the word boundary, or that loads the next word one edge late, shows a repeated or shifted bit at bit 12. Word lengths of 1 and 16 are run to catch off-by-one errors in the bit counter and in the alignment shift. The bench also aborts a word partway and then sends a full word: a design that keeps the stale bit count would deliver a word rotated by the aborted bits. Full and empty queues are driven on both sides, which exposes a design that overwrites stored words on overrun or that repeats a stale word on underrun instead of sending zeros.

// File: rtl/spi_ws_pkg.sv
package spi_ws_pkg;

  // Events seen by the shifter after pin synchronisation
  typedef struct packed {
    logic act;   // chip-select asserted
    logic rise;  // SCLK rising edge while selected
    logic fall;  // SCLK falling edge while selected
    logic mosi;  // synchronised MOSI level
  } spi_evt_t;

  localparam int unsigned PIN_COUNT = 3;

endpackage

// File: rtl/spi_ws_chain.sv
module spi_ws_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spi_ws_sync.sv
module spi_ws_sync
  import spi_ws_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_pin,
  input  logic     cs_n_pin,
  input  logic     mosi_pin,
  output spi_evt_t evt
);

  // index 0: sclk, 1: cs_n, 2: mosi
  localparam logic [PIN_COUNT-1:0] RST_VEC = 3'b010;

  logic [PIN_COUNT-1:0] pins;
  logic [PIN_COUNT-1:0] synced;
  logic                 sclk_last;

  assign pins = {mosi_pin, cs_n_pin, sclk_pin};

  generate
    for (genvar k = 0; k < PIN_COUNT; k++) begin : g_pin
      spi_ws_chain #(
        .STAGES (STAGES),
        .RST_VAL(RST_VEC[k])
      ) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins[k]),
        .q    (synced[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_last <= 1'b0;
    else        sclk_last <= synced[0];
  end

  always_comb begin
    evt.act  = ~synced[1];
    evt.rise = ~synced[1] &  synced[0] & ~sclk_last;
    evt.fall = ~synced[1] & ~synced[0] &  sclk_last;
    evt.mosi = synced[2];
  end

endmodule

// File: rtl/spi_ws_fifo.sv
module spi_ws_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;
  logic          push, pop;

  assign in_ready  = (level != FULL_LVL);
  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spi_ws_shifter.sv
module spi_ws_shifter
  import spi_ws_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  spi_evt_t             evt,
  input  logic [$clog2(W)-1:0] len_m1,
  input  logic [W-1:0]         tx_word,
  input  logic                 tx_avail,
  output logic                 tx_take,
  output logic                 underrun_evt,
  output logic                 rx_push,
  output logic [W-1:0]         rx_word,
  output logic                 miso
);

  localparam int LW = $clog2(W);

  logic [LW-1:0] bit_cnt;
  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;
  logic [LW-1:0] align_amt;
  logic [LW:0]   len_n;
  logic [W-1:0]  len_mask;
  logic [W-1:0]  aligned;
  logic          word_start;
  logic          last_bit;

  assign align_amt  = LW'(W - 1) - len_m1;
  assign len_n      = {1'b0, len_m1} + 1'b1;
  assign len_mask   = ~({W{1'b1}} << len_n);
  assign aligned    = tx_word << align_amt;
  assign word_start = evt.rise && (bit_cnt == '0);
  assign last_bit   = (bit_cnt == len_m1);

  assign tx_take      = word_start & tx_avail;
  assign underrun_evt = word_start & ~tx_avail;
  assign rx_push      = evt.fall & last_bit;
  assign rx_word      = {rx_sh[W-2:0], evt.mosi} & len_mask;
  assign miso         = tx_sh[W-1];

  // transmit side: load on the first rising edge of a word, then shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (!evt.act) begin
      tx_sh <= '0;
    end else if (word_start) begin
      tx_sh <= tx_avail ? aligned : '0;
    end else if (evt.rise) begin
      tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end

  // receive side: capture on falling edges and count bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (!evt.act) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (evt.fall) begin
      rx_sh   <= {rx_sh[W-2:0], evt.mosi};
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_ws_pkg::*;
#(
  parameter int W         = 16,
  parameter int DEPTH     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(W)-1:0] cfg_len_m1,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [W-1:0]         tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [W-1:0]         rx_data,
  output logic                 tx_underrun,
  output logic                 rx_overrun
);

  spi_evt_t     sync_evt;
  logic [W-1:0] txq_word;
  logic         txq_avail;
  logic         tx_take;
  logic         underrun_evt;
  logic         rx_push;
  logic [W-1:0] rx_word;
  logic         rxq_ready;

  spi_ws_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_pin(spi_sclk),
    .cs_n_pin(spi_cs_n),
    .mosi_pin(spi_mosi),
    .evt     (sync_evt)
  );

  spi_ws_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .out_valid(txq_avail),
    .out_ready(tx_take),
    .out_data (txq_word)
  );

  spi_ws_shifter #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (sync_evt),
    .len_m1      (cfg_len_m1),
    .tx_word     (txq_word),
    .tx_avail    (txq_avail),
    .tx_take     (tx_take),
    .underrun_evt(underrun_evt),
    .rx_push     (rx_push),
    .rx_word     (rx_word),
    .miso        (spi_miso)
  );

  spi_ws_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_push),
    .in_ready (rxq_ready),
    .in_data  (rx_word),
    .out_valid(rx_valid),
    .out_ready(rx_ready),
    .out_data (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      if (underrun_evt)          tx_underrun <= 1'b1;
      if (rx_push && !rxq_ready) rx_overrun  <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_act,
  input logic         sclk_rise,
  input logic         spi_miso,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic [W-1:0] rx_data,
  input logic         tx_underrun,
  input logic         rx_overrun
);

  // R9: deselect forces MISO low
  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);

  // R3: MISO moves only after a rising SCLK edge while selected
  assert_miso_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && (spi_miso != $past(spi_miso))) |-> $past(sclk_rise));

  // R6: a stalled receive word is held
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7: underrun flag is sticky
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun);

  // R8: overrun flag is sticky
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);

  // R8: overrun only happens with stored words present
  assert_overrun_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid);

endmodule

bind spi_word_shifter spi_word_shifter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_act     (sync_evt.act),
  .sclk_rise  (sync_evt.rise),
  .spi_miso   (spi_miso),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .tx_underrun(tx_underrun),
  .rx_overrun (rx_overrun)
);

// File: tb/spi_word_shifter_bench.sv
module spi_word_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_len_m1 = 4'd10;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        tx_underrun;
  logic        rx_overrun;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  logic [15:0] mq[$];
  logic        m_under = 1'b0;
  logic        m_over  = 1'b0;

  always #5 clk = ~clk;

  spi_word_shifter u_spi_word_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len_m1 (cfg_len_m1),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .tx_underrun(tx_underrun),
    .rx_overrun (rx_overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_tx(logic [15:0] d);
    logic acc;
    tx_valid = 1'b1;
    tx_data  = d;
    acc      = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
    if (acc) txq.push_back(d);
  endtask

  // one chip-select burst of nbits clocks at word length len
  task automatic burst(int len, int nbits);
    logic [15:0] cur = '0;
    logic [15:0] mask = 16'((32'h1 << len) - 1);
    spi_cs_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int wi = b / len;
      int bp = len - 1 - (b % len);
      if (b % len == 0) begin
        if (txq.size() > 0) cur = txq.pop_front();
        else begin cur = '0; m_under = 1'b1; end
      end
      spi_sclk = 1'b1;
      spi_mosi = mq[wi][bp];
      repeat (5) @(negedge clk);
      if (b % len == 0 && b > 0) chk("R4 MISO at word boundary", 32'(spi_miso), 32'(cur[bp]));
      else                       chk("R3 R1 MISO bit", 32'(spi_miso), 32'(cur[bp]));
      spi_sclk = 1'b0;
      repeat (5) @(negedge clk);
      if (bp == 0) begin
        if (rxq.size() < 16) rxq.push_back(mq[wi] & mask);
        else                 m_over = 1'b1;
      end
    end
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 MISO idle after deselect", 32'(spi_miso), 32'h0);
    chk("R7 underrun flag", 32'(tx_underrun), 32'(m_under));
    chk("R8 overrun flag", 32'(rx_overrun), 32'(m_over));
    mq.delete();
  endtask

  task automatic drain();
    while (rxq.size() > 0) begin
      logic [15:0] exp = rxq.pop_front();
      chk("R6 rx_valid with word queued", 32'(rx_valid), 32'h1);
      chk("R2 R6 received word", 32'(rx_data), 32'(exp));
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      @(negedge clk);
    end
    chk("R6 rx_valid after drain", 32'(rx_valid), 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 tx_ready", 32'(tx_ready), 32'h1);
    chk("R10 rx_valid", 32'(rx_valid), 32'h0);
    chk("R10 miso", 32'(spi_miso), 32'h0);
    chk("R10 tx_underrun", 32'(tx_underrun), 32'h0);
    chk("R10 rx_overrun", 32'(rx_overrun), 32'h0);

    // R4 R1: two 11-bit words in one 22-clock burst
    cfg_len_m1 = 4'd10;
    push_tx(16'h05A3);
    push_tx(16'h01C6);
    mq.push_back(16'h02B7);
    mq.push_back(16'h06E1);
    burst(11, 22);
    drain();

    // R1: 16-bit word, upper tx bits used
    cfg_len_m1 = 4'd15;
    push_tx(16'hBEEF);
    mq.push_back(16'h1234);
    burst(16, 16);
    drain();

    // R1: 1-bit words back to back
    cfg_len_m1 = 4'd0;
    push_tx(16'h0001); push_tx(16'h0000); push_tx(16'h0001); push_tx(16'h0001);
    mq.push_back(16'h0); mq.push_back(16'h1); mq.push_back(16'h1); mq.push_back(16'h0);
    burst(1, 4);
    drain();

    // R9: abort mid-word, then a clean word
    cfg_len_m1 = 4'd7;
    push_tx(16'h00C3);
    push_tx(16'h005A);
    mq.push_back(16'h00FF);
    burst(8, 5);
    chk("R9 partial word discarded", 32'(rx_valid), 32'h0);
    mq.push_back(16'h0096);
    burst(8, 8);
    drain();

    // R5: fill the transmit queue, extra word refused
    cfg_len_m1 = 4'd3;
    for (int i = 0; i < 16; i++) push_tx(16'(i + 1));
    chk("R5 tx_ready low when full", 32'(tx_ready), 32'h0);
    push_tx(16'h000A);
    chk("R5 refused push not queued", 32'(txq.size()), 32'd16);
    for (int i = 0; i < 16; i++) mq.push_back(16'(15 - i));
    burst(4, 64);
    chk("R5 tx_ready back after drain", 32'(tx_ready), 32'h1);
    // R6: stalled head word held
    held = rx_data;
    repeat (4) @(negedge clk);
    chk("R6 rx_data held while stalled", 32'(rx_data), 32'(held));
    drain();

    // R7: empty transmit queue gives zeros
    cfg_len_m1 = 4'd7;
    mq.push_back(16'h00A5);
    burst(8, 8);
    drain();

    // R8: seventeenth word with receive queue full is dropped
    cfg_len_m1 = 4'd3;
    for (int i = 0; i < 16; i++) push_tx(16'(i));
    for (int i = 0; i < 17; i++) mq.push_back(16'((i * 5 + 3) & 15));
    burst(4, 68);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule